// File: doc/BRIEF.md
# Low-Power Clock Divider Controller

This block holds a 16-bit control word that sets three clock dividers: one for a synchronous peripheral clock, one for a baud-rate clock and one for the general system clock. Each divider produces a single-cycle clock-enable pulse at a selectable fraction of the input clock. Downstream logic gates its registers with these enables, so the input clock is never stopped or altered.

Only supervisor-mode accesses reach the control word. A lock bit makes the word write-once. The write that sets the lock is still accepted. After that, the word stays fixed until a hardware reset.

The system clock normally runs at its high-frequency ratio. When the low-power enable input is raised, it uses the low-frequency ratio instead. An interrupt that is pending or in service forces the high-frequency ratio back whenever its level is strictly above a programmable threshold.

Top module: `lpcd_top`

## Requirements
- R1: After reset the control word reads 0x0000, and all three enables (`sync_ce`, `baud_ce`, `sys_ce`) pulse on every cycle.
- R2: A write with `reg_super` low leaves the control word unchanged. `reg_rdata` is zero unless `reg_rd` and `reg_super` are both high.
- R3: Bit 15 is the lock bit. While it is 0, supervisor writes load the whole word, including the write that sets bit 15. While it is 1, every write is ignored until reset.
- R4: Bits 14:13 set the `sync_ce` period: code 0 gives 1 cycle, 1 gives 4, 2 gives 16 and 3 gives 64.
- R5: Bits 12:11 set the `baud_ce` period with the same code-to-period mapping as R4.
- R6: Bits 3:1 (high field) and bits 6:4 (low field) each give a `sys_ce` period of 4^n cycles for code n. With `lowpwr_en` low, the high field is used. With `lowpwr_en` high and no qualifying interrupt, the low field is used.
- R7: While `irq_active` is high and `irq_level` is strictly greater than the threshold in bits 10:8, `sys_ce` uses the high field even when `lowpwr_en` is high.
- R8: A threshold of 7 means no interrupt level can force the high field.
- R9: A new ratio takes effect only at the next pulse. The period in progress always completes at its old length.
- R10: Bits 7 and 0 are stored and read back but have no effect on any enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_rd | input | 1 | Read strobe for the control word |
| reg_super | input | 1 | Access is in supervisor mode |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational) |
| lowpwr_en | input | 1 | Selects the low-frequency system ratio |
| irq_level | input | 3 | Level of the pending or in-service interrupt |
| irq_active | input | 1 | An interrupt is pending or being serviced |
| sync_ce | output | 1 | Synchronous peripheral clock enable |
| baud_ce | output | 1 | Baud-rate clock enable |
| sys_ce | output | 1 | System clock enable |

## Verification
The assertions check on every cycle that:
- a locked word never changes and the lock never clears;
- user-mode accesses neither write nor read data;
- a divide-by-1 setting yields back-to-back pulses on each clock;
- the gap between `sync_ce` pulses is always one of the four legal periods, which catches a truncated period.

Only the bench scenarios can show the exact period for every code, the full threshold-versus-level matrix, and that a ratio change lands exactly at the old terminal count.

// File: rtl/lpcd_pkg.sv
package lpcd_pkg;
  localparam int WORD_W = 16;
  localparam int PERI_SEL_W = 2;
  localparam int SYS_SEL_W = 3;
  localparam int THR_W = 3;

  typedef struct packed {
    logic                  lock;
    logic [PERI_SEL_W-1:0] sync_div;
    logic [PERI_SEL_W-1:0] baud_div;
    logic [THR_W-1:0]      irq_thr;
    logic                  spare_hi;
    logic [SYS_SEL_W-1:0]  lo_div;
    logic [SYS_SEL_W-1:0]  hi_div;
    logic                  spare_lo;
  } ctrl_t;
endpackage

// File: rtl/lpcd_rst_sync.sv
module lpcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lpcd_ctrl_reg.sv
module lpcd_ctrl_reg
  import lpcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_super,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output ctrl_t             ctrl
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  wr_en;

  // Writes need supervisor mode and an open lock; the locking write itself passes.
  assign wr_en = reg_wr && reg_super && !ctrl_q.lock;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = ctrl_t'(reg_wdata);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign reg_rdata = (reg_rd && reg_super) ? WORD_W'(ctrl_q) : '0;
  assign ctrl      = ctrl_q;
endmodule

// File: rtl/lpcd_divider.sv
module lpcd_divider #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel,
  output logic             ce
);
  localparam int MAX_EXP = 2 * ((1 << SEL_W) - 1);
  localparam int CNT_W   = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   ratio;
  logic [CNT_W-1:0] reload;
  logic             term;

  // Ratio is 4^sel; the reload is sampled only at the terminal count.
  assign ratio  = (CNT_W+1)'(1) << {sel, 1'b0};
  assign reload = CNT_W'(ratio - (CNT_W+1)'(1));
  assign term   = (cnt_q == '0);

  always_comb begin
    if (term) cnt_d = reload;
    else      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign ce = term;
endmodule

// File: rtl/lpcd_top.sv
module lpcd_top
  import lpcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic        reg_super,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        lowpwr_en,
  input  logic [2:0]  irq_level,
  input  logic        irq_active,
  output logic        sync_ce,
  output logic        baud_ce,
  output logic        sys_ce
);
  logic                 rst_sync_n;
  ctrl_t                ctrl_q;
  logic                 use_hi;
  logic [SYS_SEL_W-1:0] sys_sel;

  lpcd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  lpcd_ctrl_reg u_reg (
    .clk(clk), .rst_ni(rst_sync_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_super(reg_super),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl(ctrl_q)
  );

  // High field unless low-power is requested and no interrupt exceeds the threshold.
  always_comb begin
    use_hi  = !lowpwr_en || (irq_active && (irq_level > ctrl_q.irq_thr));
    sys_sel = use_hi ? ctrl_q.hi_div : ctrl_q.lo_div;
  end

  lpcd_divider #(.SEL_W(PERI_SEL_W)) u_sync_div (
    .clk(clk), .rst_ni(rst_sync_n), .sel(ctrl_q.sync_div), .ce(sync_ce)
  );

  lpcd_divider #(.SEL_W(PERI_SEL_W)) u_baud_div (
    .clk(clk), .rst_ni(rst_sync_n), .sel(ctrl_q.baud_div), .ce(baud_ce)
  );

  lpcd_divider #(.SEL_W(SYS_SEL_W)) u_sys_div (
    .clk(clk), .rst_ni(rst_sync_n), .sel(sys_sel), .ce(sys_ce)
  );
endmodule

// File: rtl/lpcd_checker.sv
module lpcd_checker (
  input logic        clk,
  input logic        rst_ni,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic        reg_super,
  input logic [15:0] reg_rdata,
  input logic [15:0] ctrl,
  input logic        lowpwr_en,
  input logic [2:0]  irq_level,
  input logic        irq_active,
  input logic        sync_ce,
  input logic        baud_ce,
  input logic        sys_ce
);
  logic [7:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (sync_ce) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (gap_q != 8'hFF) begin
        gap_q <= gap_q + 8'd1;
      end
    end
  end

  a_r2_user_write: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_wr && !reg_super) |=> $stable(ctrl));

  a_r2_user_read: assert property (@(posedge clk) disable iff (!rst_ni)
    !(reg_rd && reg_super) |-> (reg_rdata == 16'h0000));

  a_r3_lock_freeze: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(ctrl[15]) |-> $stable(ctrl));

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl[15] |=> ctrl[15]);

  a_r4_sync_div1: assert property (@(posedge clk) disable iff (!rst_ni)
    (sync_ce && ctrl[14:13] == 2'd0) |=> sync_ce);

  a_r5_baud_div1: assert property (@(posedge clk) disable iff (!rst_ni)
    (baud_ce && ctrl[12:11] == 2'd0) |=> baud_ce);

  a_r7_irq_hi_div1: assert property (@(posedge clk) disable iff (!rst_ni)
    (sys_ce && irq_active && (irq_level > ctrl[10:8]) && ctrl[3:1] == 3'd0) |=> sys_ce);

  a_r9_no_truncation: assert property (@(posedge clk) disable iff (!rst_ni)
    (sync_ce && seen_q) |-> (gap_q == 8'd0 || gap_q == 8'd3 || gap_q == 8'd15 || gap_q == 8'd63));
endmodule

bind lpcd_top lpcd_checker u_chk (
  .clk(clk), .rst_ni(rst_sync_n),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_super(reg_super),
  .reg_rdata(reg_rdata), .ctrl(16'(ctrl_q)),
  .lowpwr_en(lowpwr_en), .irq_level(irq_level), .irq_active(irq_active),
  .sync_ce(sync_ce), .baud_ce(baud_ce), .sys_ce(sys_ce)
);

// File: tb/lpcd_top_test.sv
`timescale 1ns/1ps
module lpcd_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd, reg_super;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        lowpwr_en;
  logic [2:0]  irq_level;
  logic        irq_active;
  logic        sync_ce, baud_ce, sys_ce;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lpcd_top uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_super(reg_super),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lowpwr_en(lowpwr_en), .irq_level(irq_level), .irq_active(irq_active),
    .sync_ce(sync_ce), .baud_ce(baud_ce), .sys_ce(sys_ce)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit lk, input int sy, input int bd,
                                     input int th, input int lo, input int hi);
    return {lk, 2'(sy), 2'(bd), 3'(th), 1'b0, 3'(lo), 3'(hi), 1'b0};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d, input bit sup);
    @(negedge clk);
    reg_wr = 1'b1; reg_super = sup; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_super = 1'b0;
  endtask

  task automatic rd(input bit sup, output int v);
    @(negedge clk);
    reg_rd = 1'b1; reg_super = sup;
    #1 v = int'(reg_rdata);
    reg_rd = 1'b0; reg_super = 1'b0;
  endtask

  function automatic bit sig(input int w);
    return (w == 0) ? sync_ce : (w == 1) ? baud_ce : sys_ce;
  endfunction

  task automatic wait_pulse(input int w, output int at);
    do @(negedge clk); while (!sig(w));
    at = cyc;
  endtask

  task automatic period(input int w, output int p);
    int a, b;
    wait_pulse(w, a);
    wait_pulse(w, b);
    p = b - a;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int v, p, p0, p1;
    reg_wr = 0; reg_rd = 0; reg_super = 0; reg_wdata = '0;
    lowpwr_en = 0; irq_level = 0; irq_active = 0;
    do_reset();

    // R1 reset state
    rd(1, v); check("R1 reset word", v, 0);
    for (int w = 0; w < 3; w++) begin
      period(w, p); check("R1 reset period", p, 1);
    end

    // R2 user mode
    wr(16'h7FFE, 0);
    rd(1, v); check("R2 user write ignored", v, 0);
    wr(mk(0, 1, 2, 3, 0, 0), 1);
    rd(0, v); check("R2 user read zero", v, 0);
    @(negedge clk); #1 check("R2 idle rdata zero", int'(reg_rdata), 0);

    // R4 / R5 sweeps of peripheral dividers
    for (int c = 0; c < 4; c++) begin
      wr(mk(0, c, 3 - c, 0, 0, 0), 1);
      period(0, p); check("R4 sync period", p, 1 << (2 * c));
      period(1, p); check("R5 baud period", p, 1 << (2 * (3 - c)));
    end

    // R10 spare bits stored
    wr(16'h0081, 1);
    rd(1, v); check("R10 spare readback", v, 16'h0081);
    period(0, p); check("R10 spare no effect", p, 1);
    period(2, p); check("R10 spare no effect sys", p, 1);

    // R6 system fields
    lowpwr_en = 1'b1;
    for (int n = 0; n < 6; n++) begin
      wr(mk(0, 0, 0, 7, n, 1), 1);
      period(2, p); check("R6 low field period", p, 1 << (2 * n));
    end
    wr(mk(0, 0, 0, 7, 7, 1), 1);
    period(2, p); check("R6 low field code 7", p, 16384);
    lowpwr_en = 1'b0;
    period(2, p); check("R6 high field when not low-power", p, 4);

    // R7 / R8 threshold vs level matrix
    lowpwr_en = 1'b1;
    for (int t = 0; t < 8; t++) begin
      wr(mk(0, 0, 0, t, 2, 0), 1);
      for (int l = 0; l < 8; l++) begin
        irq_active = 1'b1; irq_level = 3'(l);
        period(2, p);
        if (t == 7) check("R8 thr7 never forces", p, 16);
        else        check("R7 irq override", p, (l > t) ? 1 : 16);
      end
    end
    irq_active = 1'b0; irq_level = 3'd7;
    wr(mk(0, 0, 0, 0, 2, 0), 1);
    period(2, p); check("R7 inactive irq ignored", p, 16);
    lowpwr_en = 1'b0; irq_level = 0;

    // R9 ratio change mid-period
    wr(mk(0, 3, 0, 0, 0, 0), 1);
    wait_pulse(0, p0);
    repeat (10) @(negedge clk);
    wr(mk(0, 0, 0, 0, 0, 0), 1);
    wait_pulse(0, p1); check("R9 old period completes", p1 - p0, 64);
    wait_pulse(0, p0); check("R9 new period applies", p0 - p1, 1);

    // R3 lock
    wr(mk(1, 2, 1, 7, 0, 0), 1);
    rd(1, v); check("R3 locking write accepted", v, int'(mk(1, 2, 1, 7, 0, 0)));
    wr(16'h0000, 1);
    rd(1, v); check("R3 locked write ignored", v, int'(mk(1, 2, 1, 7, 0, 0)));
    period(0, p); check("R3 locked sync kept", p, 16);
    do_reset();
    rd(1, v); check("R3 reset clears lock", v, 0);
    wr(mk(0, 1, 0, 0, 0, 0), 1);
    rd(1, v); check("R3 writable after reset", v, int'(mk(0, 1, 0, 0, 0, 0)));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule